// File: doc/BRIEF.md
# Two-Thread History-Indexed Branch Predictor

This block guesses the direction and target of branches for a core that runs two hardware threads in order. On the fetch side it takes a thread number and a fetch address and returns, in the same cycle, a direction guess, a hit indication from a small target cache and the cached target. The direction comes from one table of 2-bit saturating counters that both threads share. Each thread indexes that table through its own shift register of recent conditional outcomes, mixed with address bits. The block signals a taken fetch only when the direction is taken and the target cache also supplies an address. Otherwise fetch falls through.

On the resolve side the pipeline reports each executed branch. The report carries the thread, the address, the kind, the real outcome, the real target and the guess that fetch acted on. Conditional branches update the thread's history, the counter and the target cache. Unconditional jumps leave all predictor state alone. Every target-cache entry carries a static bias mark. The mark is set from the first resolved outcome and overrides the counter until the branch first goes the other way. It is then cleared for good. One cycle after a resolve, two flags tell the pipeline which redirect penalty applies: the long one for a wrong direction, the short one for a correct taken guess that had no target.

Neither side has back-pressure. The lookup is combinational and answers whatever address is on the fetch inputs in every cycle. A resolve is accepted in any cycle in which its valid is high, and no ready is returned.

Top module: `twolvl_predictor`

## Requirements
- R1: After reset, every history register reads zero, every target-cache entry is invalid and every counter holds weakly not-taken (2'b01). A lookup then returns pd_dir=0, pd_hit=0 and pd_taken=0.
- R2: Each thread keeps its own HIST_W-bit history (default 10). A resolved conditional branch shifts its outcome into bit 0 of that thread's history (1 = taken). The shared counter table is indexed by {pc[HIST_W+2], history ^ pc[HIST_W+1:2]}, so the same address can read different counters for the two threads.
- R3: Counters are 2-bit saturating counters. A taken outcome increments the counter and a not-taken outcome decrements it, both at the resolve index. The counter MSB gives the dynamic direction.
- R4: An unconditional resolve (rs_cond=0) changes no history, no counter and no target-cache entry, and raises neither redirect flag.
- R5: The target cache has 32 sets of 4 ways, selected by pc[6:2] and tagged with pc[31:7]. Both threads share it. A resolved conditional branch that misses the cache is allocated with rs_target.
- R6: A new entry takes a static mark from its outcome: always-taken when taken, never-taken when not taken. While the mark is present, a hitting lookup takes its direction from the mark and not from the counter.
- R7: The first resolve that goes against the mark clears it permanently. Later outcomes never set it again, and the counter governs from then on.
- R8: pd_taken is 1 only when pd_dir=1 and pd_hit=1. On a hit, pd_target is the target stored by the most recent resolve of that branch.
- R9: rd_mispredict is 1 in the cycle after a conditional resolve whose rs_pred_dir differs from rs_taken, and 0 otherwise.
- R10: rd_btb_miss is 1 in the cycle after a conditional resolve with rs_pred_dir=1, rs_taken=1 and rs_pred_hit=0, and 0 otherwise. The two flags are never high together.
- R11: An allocation fills the lowest-numbered invalid way of the set. When all four ways are valid, it replaces the way chosen by a 3-bit tree pseudo-LRU. Each allocation or hitting resolve makes its own way the most recently used.
- R12: A lookup and a resolve in the same cycle see the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_tid | input | TID_W | Thread of the fetch lookup |
| lu_pc | input | PC_W | Fetch address to predict |
| pd_dir | output | 1 | Predicted direction (1 = taken) |
| pd_hit | output | 1 | Target cache holds this address |
| pd_taken | output | 1 | Redirect fetch to pd_target |
| pd_target | output | PC_W | Cached target, 0 on a miss |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_tid | input | TID_W | Thread of the resolved branch |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_cond | input | 1 | 1 = conditional, 0 = unconditional |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | PC_W | Actual branch target |
| rs_pred_dir | input | 1 | Direction fetch used for this branch |
| rs_pred_hit | input | 1 | Whether fetch hit the target cache |
| rd_mispredict | output | 1 | Long redirect: direction was wrong |
| rd_btb_miss | output | 1 | Short redirect: taken guess had no target |

## Verification
The assertions assume that the pipeline reports the guess fetch really made, and in particular that rs_pred_dir and rs_pred_hit are driven whenever rs_valid is high. The hold property also assumes that lookup outputs depend only on the lookup inputs and on state changed by resolves. The stimulus drives every resolve field together with rs_valid and leaves rs_valid low between reports. It moves the lookup inputs only at falling edges, so each lookup result is checked against a state that is known to be settled.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  typedef enum logic [1:0] {
    BIAS_DYN = 2'b00,
    BIAS_NT  = 2'b01,
    BIAS_AT  = 2'b10
  } bias_e;

  // 3-bit tree: b[0] root (0 -> victim in ways 0/1), b[1] left pair, b[2] right pair
  function automatic logic [1:0] plru_victim(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] way);
    logic [2:0] n;
    n = b;
    unique case (way)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tlp_history.sv
module tlp_history #(
  parameter int THREADS = 2,
  parameter int HIST_W  = 10,
  parameter int TID_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [TID_W-1:0]  upd_tid,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist [THREADS]
);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        hist[t] <= '0;
      else if (upd_en && (upd_tid == TID_W'(t)))
        hist[t] <= {hist[t][HIST_W-2:0], upd_taken};
    end
  end

endmodule

// File: rtl/tlp_counters.sv
module tlp_counters #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] ctr [ENTRIES];

  assign rd_msb = ctr[rd_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= 2'b01;
    end else if (wr_en) begin
      if (wr_taken && ctr[wr_idx] != 2'b11)
        ctr[wr_idx] <= ctr[wr_idx] + 2'b01;
      else if (!wr_taken && ctr[wr_idx] != 2'b00)
        ctr[wr_idx] <= ctr[wr_idx] - 2'b01;
    end
  end

endmodule

// File: rtl/tlp_target_buf.sv
module tlp_target_buf
  import tlp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SET_W = 5,
  parameter int TAG_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lu_set,
  input  logic [TAG_W-1:0] lu_tag,
  output logic             lu_hit,
  output logic [PC_W-1:0]  lu_target,
  output bias_e            lu_bias,
  input  logic             up_en,
  input  logic [SET_W-1:0] up_set,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_taken,
  input  logic [PC_W-1:0]  up_target
);

  localparam int SETS = 1 << SET_W;
  localparam int WAYS = 4;

  logic             vld    [SETS][WAYS];
  logic [TAG_W-1:0] tags   [SETS][WAYS];
  logic [PC_W-1:0]  tgts   [SETS][WAYS];
  bias_e            bias_q [SETS][WAYS];
  logic [2:0]       plru   [SETS];

  logic [WAYS-1:0] lu_match, up_match, up_free;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lu_match[w] = vld[lu_set][w] && (tags[lu_set][w] == lu_tag);
    assign up_match[w] = vld[up_set][w] && (tags[up_set][w] == up_tag);
    assign up_free[w]  = !vld[up_set][w];
  end

  always_comb begin
    lu_hit    = 1'b0;
    lu_target = '0;
    lu_bias   = BIAS_DYN;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lu_match[w]) begin
        lu_hit    = 1'b1;
        lu_target = tgts[lu_set][w];
        lu_bias   = bias_q[lu_set][w];
      end
    end
  end

  logic       up_hit;
  logic [1:0] up_way;

  always_comb begin
    up_hit = |up_match;
    up_way = plru_victim(plru[up_set]);
    if (up_hit) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (up_match[w]) up_way = 2'(w);
    end else if (|up_free) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (up_free[w]) up_way = 2'(w);
    end
  end

  logic against;
  assign against = (bias_q[up_set][up_way] == BIAS_AT && !up_taken) ||
                   (bias_q[up_set][up_way] == BIAS_NT &&  up_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
      end
    end else if (up_en) begin
      tgts[up_set][up_way] <= up_target;
      if (up_hit) begin
        if (against) bias_q[up_set][up_way] <= BIAS_DYN;
      end else begin
        vld[up_set][up_way]    <= 1'b1;
        tags[up_set][up_way]   <= up_tag;
        bias_q[up_set][up_way] <= up_taken ? BIAS_AT : BIAS_NT;
      end
      plru[up_set] <= plru_touch(plru[up_set], up_way);
    end
  end

endmodule

// File: rtl/twolvl_predictor.sv
module twolvl_predictor
  import tlp_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int PC_W    = 32,
  parameter int HIST_W  = 10,
  parameter int SET_W   = 5,
  parameter int TID_W   = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] lu_tid,
  input  logic [PC_W-1:0]  lu_pc,
  output logic             pd_dir,
  output logic             pd_hit,
  output logic             pd_taken,
  output logic [PC_W-1:0]  pd_target,
  input  logic             rs_valid,
  input  logic [TID_W-1:0] rs_tid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_cond,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  input  logic             rs_pred_dir,
  input  logic             rs_pred_hit,
  output logic             rd_mispredict,
  output logic             rd_btb_miss
);

  localparam int IDX_W = HIST_W + 1;
  localparam int TAG_W = PC_W - SET_W - 2;

  logic              upd;
  logic [HIST_W-1:0] hist [THREADS];
  logic [IDX_W-1:0]  lu_idx, rs_idx;
  logic              ctr_msb, bt_hit;
  logic [PC_W-1:0]   bt_target;
  bias_e             bt_bias;

  assign upd    = rs_valid && rs_cond;
  assign lu_idx = {lu_pc[HIST_W+2], hist[lu_tid] ^ lu_pc[HIST_W+1:2]};
  assign rs_idx = {rs_pc[HIST_W+2], hist[rs_tid] ^ rs_pc[HIST_W+1:2]};

  tlp_history #(.THREADS(THREADS), .HIST_W(HIST_W), .TID_W(TID_W)) i_hist (
    .clk(clk), .rst_n(rst_n), .upd_en(upd), .upd_tid(rs_tid),
    .upd_taken(rs_taken), .hist(hist)
  );

  tlp_counters #(.IDX_W(IDX_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .rd_idx(lu_idx), .rd_msb(ctr_msb),
    .wr_en(upd), .wr_idx(rs_idx), .wr_taken(rs_taken)
  );

  tlp_target_buf #(.PC_W(PC_W), .SET_W(SET_W), .TAG_W(TAG_W)) i_btb (
    .clk(clk), .rst_n(rst_n),
    .lu_set(lu_pc[SET_W+1:2]), .lu_tag(lu_pc[PC_W-1:SET_W+2]),
    .lu_hit(bt_hit), .lu_target(bt_target), .lu_bias(bt_bias),
    .up_en(upd), .up_set(rs_pc[SET_W+1:2]), .up_tag(rs_pc[PC_W-1:SET_W+2]),
    .up_taken(rs_taken), .up_target(rs_target)
  );

  always_comb begin
    pd_dir = ctr_msb;
    if (bt_hit && bt_bias == BIAS_AT) pd_dir = 1'b1;
    if (bt_hit && bt_bias == BIAS_NT) pd_dir = 1'b0;
  end

  assign pd_hit    = bt_hit;
  assign pd_taken  = pd_dir && bt_hit;
  assign pd_target = bt_target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mispredict <= 1'b0;
      rd_btb_miss   <= 1'b0;
    end else begin
      rd_mispredict <= upd && (rs_pred_dir != rs_taken);
      rd_btb_miss   <= upd && rs_pred_dir && rs_taken && !rs_pred_hit;
    end
  end

endmodule

// File: rtl/twolvl_predictor_chk.sv
module twolvl_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int TID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TID_W-1:0] lu_tid,
  input logic [PC_W-1:0]  lu_pc,
  input logic             pd_dir,
  input logic             pd_hit,
  input logic             pd_taken,
  input logic [PC_W-1:0]  pd_target,
  input logic             rs_valid,
  input logic             rs_cond,
  input logic             rs_taken,
  input logic             rs_pred_dir,
  input logic             rs_pred_hit,
  input logic             rd_mispredict,
  input logic             rd_btb_miss
);

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_mispredict && rd_btb_miss));

  p_uncond_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_cond) |=> (!rd_mispredict && !rd_btb_miss));

  p_mis_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mispredict |-> $past(rs_valid && rs_cond && (rs_pred_dir != rs_taken)));

  p_mis_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_cond && (rs_pred_dir != rs_taken)) |=> rd_mispredict);

  p_short_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_btb_miss |-> $past(rs_valid && rs_cond && rs_taken && !rs_pred_hit));

  p_no_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_hit |-> (!pd_taken && pd_target == '0));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rs_valid) && $stable(lu_pc) && $stable(lu_tid))
      |-> ($stable(pd_dir) && $stable(pd_hit) && $stable(pd_target)));

endmodule

bind twolvl_predictor twolvl_predictor_chk #(.PC_W(PC_W), .TID_W(TID_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .lu_tid(lu_tid), .lu_pc(lu_pc),
  .pd_dir(pd_dir), .pd_hit(pd_hit), .pd_taken(pd_taken), .pd_target(pd_target),
  .rs_valid(rs_valid), .rs_cond(rs_cond), .rs_taken(rs_taken),
  .rs_pred_dir(rs_pred_dir), .rs_pred_hit(rs_pred_hit),
  .rd_mispredict(rd_mispredict), .rd_btb_miss(rd_btb_miss)
);

// File: tb/test_twolvl_predictor.sv
module test_twolvl_predictor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:0]  lu_tid, rs_tid;
  logic [31:0] lu_pc, rs_pc, rs_target, pd_target;
  logic        pd_dir, pd_hit, pd_taken;
  logic        rs_valid, rs_cond, rs_taken, rs_pred_dir, rs_pred_hit;
  logic        rd_mispredict, rd_btb_miss;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twolvl_predictor i_twolvl_predictor (
    .clk(clk), .rst_n(rst_n), .lu_tid(lu_tid), .lu_pc(lu_pc),
    .pd_dir(pd_dir), .pd_hit(pd_hit), .pd_taken(pd_taken), .pd_target(pd_target),
    .rs_valid(rs_valid), .rs_tid(rs_tid), .rs_pc(rs_pc), .rs_cond(rs_cond),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_dir(rs_pred_dir),
    .rs_pred_hit(rs_pred_hit), .rd_mispredict(rd_mispredict), .rd_btb_miss(rd_btb_miss)
  );

  // [5]=cond [4]=pred_dir [3]=pred_hit [2]=taken [1]=exp mispredict [0]=exp btb_miss
  localparam logic [5:0] VEC [7] = '{
    6'b100000, 6'b100110, 6'b110101, 6'b111100,
    6'b111010, 6'b010100, 6'b110010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic tid, input logic [31:0] pc);
    @(negedge clk);
    lu_tid = tid;
    lu_pc  = pc;
    #1;
  endtask

  task automatic res(input logic tid, input logic [31:0] pc, input logic cond,
                     input logic tk, input logic [31:0] tgt, input logic pdir,
                     input logic phit);
    @(negedge clk);
    rs_tid = tid; rs_pc = pc; rs_cond = cond; rs_taken = tk;
    rs_target = tgt; rs_pred_dir = pdir; rs_pred_hit = phit;
    rs_valid = 1'b1;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lu_tid = '0; lu_pc = '0; rs_valid = 1'b0; rs_tid = '0; rs_pc = '0;
    rs_cond = 1'b0; rs_taken = 1'b0; rs_target = '0; rs_pred_dir = 1'b0;
    rs_pred_hit = 1'b0;
    do_reset();

    // redirect flag table (R9, R10, R4)
    for (int i = 0; i < 7; i++) begin
      res(1'b1, 32'h3008, VEC[i][5], VEC[i][2], 32'h3100, VEC[i][4], VEC[i][3]);
      chk($sformatf("R9 vec%0d mispredict", i), {31'd0, rd_mispredict}, {31'd0, VEC[i][1]});
      chk($sformatf("R10 vec%0d btb_miss", i), {31'd0, rd_btb_miss}, {31'd0, VEC[i][0]});
    end

    do_reset();
    // R1 reset state
    look(1'b0, 32'h3008);
    chk("R1 hit after reset", {31'd0, pd_hit}, 32'd0);
    chk("R1 dir after reset", {31'd0, pd_dir}, 32'd0);
    chk("R1 taken after reset", {31'd0, pd_taken}, 32'd0);
    look(1'b0, 32'h100);
    chk("R1 dir weak not-taken", {31'd0, pd_dir}, 32'd0);

    // R5/R6 allocate taken branch, static always-taken overrides counter
    res(1'b0, 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, 1'b0);
    chk("R9 first resolve mispredict", {31'd0, rd_mispredict}, 32'd1);
    look(1'b0, 32'h100);
    chk("R5 allocated hit", {31'd0, pd_hit}, 32'd1);
    chk("R6 static taken dir", {31'd0, pd_dir}, 32'd1);
    chk("R8 taken with hit", {31'd0, pd_taken}, 32'd1);
    chk("R8 target", pd_target, 32'h400);
    look(1'b1, 32'h100);
    chk("R5 shared across threads", {31'd0, pd_hit}, 32'd1);

    // R12 same-cycle lookup and resolve; R7 clears the mark
    @(negedge clk);
    lu_tid = 1'b0; lu_pc = 32'h100;
    rs_tid = 1'b0; rs_pc = 32'h100; rs_cond = 1'b1; rs_taken = 1'b0;
    rs_target = 32'h400; rs_pred_dir = 1'b1; rs_pred_hit = 1'b1; rs_valid = 1'b1;
    #1;
    chk("R12 pre-update dir", {31'd0, pd_dir}, 32'd1);
    @(negedge clk);
    rs_valid = 1'b0;
    look(1'b0, 32'h100);
    chk("R7 mark cleared dir", {31'd0, pd_dir}, 32'd0);
    chk("R8 hit not taken", {31'd0, pd_taken}, 32'd0);
    chk("R8 target kept", pd_target, 32'h400);

    // R2 per-thread history: thread 1 still at zero history -> taken counter
    look(1'b1, 32'h100);
    chk("R2 thread1 dir", {31'd0, pd_dir}, 32'd1);
    chk("R3 counter taken", {31'd0, pd_taken}, 32'd1);

    // R4 unconditional jump ignored
    res(1'b1, 32'h800, 1'b0, 1'b1, 32'h900, 1'b1, 1'b0);
    chk("R4 no mispredict flag", {31'd0, rd_mispredict}, 32'd0);
    chk("R4 no btb flag", {31'd0, rd_btb_miss}, 32'd0);
    look(1'b1, 32'h100);
    chk("R4 history unchanged", {31'd0, pd_dir}, 32'd1);
    look(1'b1, 32'h800);
    chk("R4 not allocated", {31'd0, pd_hit}, 32'd0);

    // R7 permanence: taken again must not bring back the mark
    res(1'b0, 32'h100, 1'b1, 1'b1, 32'h440, 1'b0, 1'b1);
    look(1'b0, 32'h100);
    chk("R7 stays dynamic", {31'd0, pd_dir}, 32'd0);
    chk("R8 target refreshed", pd_target, 32'h440);

    // R6 never-taken mark
    res(1'b1, 32'h200, 1'b1, 1'b0, 32'h600, 1'b0, 1'b0);
    look(1'b1, 32'h200);
    chk("R6 never-taken hit", {31'd0, pd_hit}, 32'd1);
    chk("R6 never-taken dir", {31'd0, pd_dir}, 32'd0);

    // R11 replacement in set 1
    res(1'b0, 32'h1004, 1'b1, 1'b1, 32'hA0, 1'b0, 1'b0);
    res(1'b0, 32'h2004, 1'b1, 1'b1, 32'hB0, 1'b0, 1'b0);
    res(1'b0, 32'h1004, 1'b1, 1'b1, 32'hA0, 1'b1, 1'b1);
    res(1'b0, 32'h3004, 1'b1, 1'b1, 32'hC0, 1'b0, 1'b0);
    res(1'b0, 32'h4004, 1'b1, 1'b1, 32'hD0, 1'b0, 1'b0);
    res(1'b0, 32'h5004, 1'b1, 1'b1, 32'hE0, 1'b0, 1'b0);
    look(1'b0, 32'h2004);
    chk("R11 pseudo-LRU victim evicted", {31'd0, pd_hit}, 32'd0);
    look(1'b0, 32'h1004);
    chk("R11 recently used kept", {31'd0, pd_hit}, 32'd1);
    look(1'b0, 32'h5004);
    chk("R11 new entry target", pd_target, 32'hE0);
    look(1'b0, 32'h3004);
    chk("R11 third way kept", {31'd0, pd_hit}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule